// File: doc/BRIEF.md
# Three-Entry Push-Down Accumulator Register Stack

This block holds one accumulator-class register as a small push-down stack of three 16-bit entries: a top entry that the datapath reads and writes, a next entry and a bottom entry. Ordinary loads overwrite only the top entry. Nothing is pushed or popped behind the programmer's back. Three single-cycle stack commands (duplicate, swap, rotate) keep intermediate results on chip without a trip through memory.

A two-bit modifier code travels with each stack command. When the accumulator extensions are enabled by parameter, the modifiers change the commands. Swap can instead exchange the two bytes of the top entry. Rotate can instead turn the top entry right by one nibble. Duplicate can instead move data between the top entry and a separate 16-bit interpreter pointer register, in either direction, or swap the two. A width select masks load data to 8 bits when narrow operation is chosen.

Top module: `pushdown_regfile`

## Requirements
- R1: After reset the top, next and bottom entries and the interpreter pointer all read zero.
- R2: Command code 01 with modifier 00 (duplicate) turns {top,next,bottom} into {top,top,next} in the cycle after it is applied.
- R3: Command code 10 with modifier 00 (swap) turns {top,next,bottom} into {next,top,bottom}.
- R4: Command code 11 with modifier 00 (rotate) turns {top,next,bottom} into {next,bottom,top}.
- R5: A load strobe with command code 00 writes only the top entry: next, bottom and the pointer keep their values. With no load and command 00, all state holds.
- R6: With the width select low, a load writes zero into the upper byte and data bits 7:0 into the lower byte. With it high, all 16 data bits are written.
- R7: A load in the same cycle as a stack command first applies the command and then overwrites the top entry with the load value.
- R8: Swap with modifier bit 0 (indirection) set exchanges the upper and lower bytes of the top entry and leaves next and bottom unchanged.
- R9: Rotate with modifier bit 0 set replaces the top entry with {top[3:0], top[15:4]} and leaves next and bottom unchanged.
- R10: Duplicate with modifier 01 copies the top entry into the pointer and leaves all three entries unchanged.
- R11: Duplicate with modifier 10 (bit 1, size) copies the pointer into the top entry and leaves next, bottom and the pointer unchanged.
- R12: Duplicate with modifier 11 exchanges the top entry and the pointer. Next and bottom are unchanged.
- R13: On swap and rotate, modifier bit 1 alone has no effect: the plain command is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load strobe for the top entry |
| ld_data | input | 16 | Load value |
| wide | input | 1 | 1 selects 16-bit load, 0 selects 8-bit load with zeroed upper byte |
| cmd | input | 2 | Stack command: 00 none, 01 duplicate, 10 swap, 11 rotate |
| mod | input | 2 | Modifier: bit 0 indirection, bit 1 size |
| tos | output | 16 | Current top entry |
| ip | output | 16 | Current interpreter pointer |

## Verification
Every result in this block comes from a single register stage. A command or load sampled at one rising edge appears on `tos` and `ip` after that same edge, with no further latency. The bench drives each stimulus on a falling edge and removes it at the next falling edge. It reads the outputs at that falling edge, half a period after the edge that acted. The next and bottom entries are not ports. The bench brings them out through three plain rotates and reads the top entry after each one. The third rotate restores the original order, so every later check starts from a known stack.

// File: rtl/pdrf_pkg.sv
package pdrf_pkg;

   // command field as seen on the cmd port
   typedef enum logic [1:0] {
      CMD_NONE = 2'b00,
      CMD_DUP  = 2'b01,
      CMD_SWP  = 2'b10,
      CMD_ROT  = 2'b11
   } stk_cmd_e;

   // modifier field: bit 1 = size, bit 0 = indirection
   typedef struct packed {
      logic size;
      logic ind;
   } stk_mod_t;

   // internal operation after modifier decode
   typedef enum logic [3:0] {
      OP_HOLD  = 4'd0,
      OP_DUP   = 4'd1,
      OP_SWP   = 4'd2,
      OP_ROT   = 4'd3,
      OP_HSWAP = 4'd4,   // exchange halves of top
      OP_NROT  = 4'd5,   // rotate top right one nibble
      OP_TOP2P = 4'd6,   // pointer <- top
      OP_P2TOP = 4'd7,   // top <- pointer
      OP_XCHG  = 4'd8    // top <-> pointer
   } stk_op_e;

   localparam int unsigned NIBBLE_W = 4;

endpackage

// File: rtl/pdrf_decode.sv
module pdrf_decode
   import pdrf_pkg::*;
#(
   parameter bit ACC_EXT = 1'b1
) (
   input  stk_cmd_e cmd_i,
   input  stk_mod_t mod_i,
   output stk_op_e  op_o
);

   generate
      if (ACC_EXT) begin : g_ext
         always_comb begin
            op_o = OP_HOLD;
            unique case (cmd_i)
               CMD_NONE: op_o = OP_HOLD;
               CMD_DUP: begin
                  unique case ({mod_i.size, mod_i.ind})
                     2'b00: op_o = OP_DUP;
                     2'b01: op_o = OP_TOP2P;
                     2'b10: op_o = OP_P2TOP;
                     default: op_o = OP_XCHG;
                  endcase
               end
               CMD_SWP: op_o = mod_i.ind ? OP_HSWAP : OP_SWP;
               default: op_o = mod_i.ind ? OP_NROT : OP_ROT;
            endcase
         end
      end else begin : g_plain
         logic unused_mod;
         assign unused_mod = ^mod_i;
         always_comb begin
            op_o = OP_HOLD;
            unique case (cmd_i)
               CMD_NONE: op_o = OP_HOLD;
               CMD_DUP:  op_o = OP_DUP;
               CMD_SWP:  op_o = OP_SWP;
               default:  op_o = OP_ROT;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/pdrf_load_fmt.sv
module pdrf_load_fmt #(
   parameter int unsigned DW     = 16,
   parameter int unsigned NARROW = 8
) (
   input  logic          wide_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] data_o
);

   localparam int unsigned UPPER = DW - NARROW;

   generate
      if (UPPER == 0) begin : g_same
         logic unused_wide;
         assign unused_wide = wide_i;
         assign data_o = data_i;
      end else begin : g_mask
         assign data_o = wide_i ? data_i : {{UPPER{1'b0}}, data_i[NARROW-1:0]};
      end
   endgenerate

endmodule

// File: rtl/pdrf_entries.sv
module pdrf_entries
   import pdrf_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op_i,
   input  logic          ld_en_i,
   input  logic [DW-1:0] ld_val_i,
   input  logic [DW-1:0] ptr_i,
   output logic [DW-1:0] tos_o
);

   localparam int unsigned HALF = DW / 2;

   logic [DW-1:0] top_q, mid_q, bot_q;
   logic [DW-1:0] top_d, mid_d, bot_d;
   logic [DW-1:0] top_cmd;

   always_comb begin
      top_cmd = top_q;
      mid_d   = mid_q;
      bot_d   = bot_q;
      unique case (op_i)
         OP_DUP: begin
            mid_d = top_q;
            bot_d = mid_q;
         end
         OP_SWP: begin
            top_cmd = mid_q;
            mid_d   = top_q;
         end
         OP_ROT: begin
            top_cmd = mid_q;
            mid_d   = bot_q;
            bot_d   = top_q;
         end
         OP_HSWAP: top_cmd = {top_q[HALF-1:0], top_q[DW-1:HALF]};
         OP_NROT:  top_cmd = {top_q[NIBBLE_W-1:0], top_q[DW-1:NIBBLE_W]};
         OP_P2TOP, OP_XCHG: top_cmd = ptr_i;
         default: ;
      endcase
      top_d = ld_en_i ? ld_val_i : top_cmd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
         mid_q <= '0;
         bot_q <= '0;
      end else begin
         top_q <= top_d;
         mid_q <= mid_d;
         bot_q <= bot_d;
      end
   end

   assign tos_o = top_q;

   assert_dup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_DUP && !ld_en_i) |=>
         (top_q == $past(top_q) && mid_q == $past(top_q) && bot_q == $past(mid_q)));

   assert_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SWP && !ld_en_i) |=>
         (top_q == $past(mid_q) && mid_q == $past(top_q) && bot_q == $past(bot_q)));

   assert_rot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_ROT && !ld_en_i) |=>
         (top_q == $past(mid_q) && mid_q == $past(bot_q) && bot_q == $past(top_q)));

   assert_load_only_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_HOLD) |=> ($stable(mid_q) && $stable(bot_q)));

   assert_load_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i |=> (top_q == $past(ld_val_i)));

   assert_halfswap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_HSWAP && !ld_en_i) |=>
         (top_q[DW-1:HALF] == $past(top_q[HALF-1:0]) && $stable(mid_q) && $stable(bot_q)));

   assert_nibrot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_NROT && !ld_en_i) |=>
         (top_q[DW-1:DW-NIBBLE_W] == $past(top_q[NIBBLE_W-1:0]) && $stable(mid_q)));

endmodule

// File: rtl/pdrf_ptr_reg.sv
module pdrf_ptr_reg
   import pdrf_pkg::*;
#(
   parameter int unsigned DW      = 16,
   parameter bit          PRESENT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op_i,
   input  logic [DW-1:0] top_i,
   output logic [DW-1:0] ptr_o
);

   generate
      if (PRESENT) begin : g_reg
         logic [DW-1:0] ptr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr_q <= '0;
            else if (op_i == OP_TOP2P || op_i == OP_XCHG)
               ptr_q <= top_i;
         end
         assign ptr_o = ptr_q;

         assert_ptr_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == OP_TOP2P) |=> (ptr_o == $past(top_i)));

         assert_ptr_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == OP_P2TOP || op_i == OP_HOLD) |=> $stable(ptr_o));
      end else begin : g_none
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ (^op_i) ^ (^top_i);
         assign ptr_o = '0;
      end
   endgenerate

endmodule

// File: rtl/pushdown_regfile.sv
module pushdown_regfile
   import pdrf_pkg::*;
#(
   parameter int unsigned DW      = 16,
   parameter bit          ACC_EXT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [DW-1:0] ld_data,
   input  logic          wide,
   input  logic [1:0]    cmd,
   input  logic [1:0]    mod,
   output logic [DW-1:0] tos,
   output logic [DW-1:0] ip
);

   localparam int unsigned NARROW = 8;

   generate
      if (DW < 2 * NARROW || (DW % NARROW) != 0) begin : g_bad_width
         $error("pushdown_regfile: DW must be a multiple of 8 and at least 16");
      end
   endgenerate

   stk_op_e       op;
   logic [DW-1:0] ld_val;

   pdrf_decode #(.ACC_EXT(ACC_EXT)) u_dec (
      .cmd_i (stk_cmd_e'(cmd)),
      .mod_i (stk_mod_t'(mod)),
      .op_o  (op)
   );

   pdrf_load_fmt #(.DW(DW), .NARROW(NARROW)) u_fmt (
      .wide_i (wide),
      .data_i (ld_data),
      .data_o (ld_val)
   );

   pdrf_entries #(.DW(DW)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op),
      .ld_en_i  (ld_en),
      .ld_val_i (ld_val),
      .ptr_i    (ip),
      .tos_o    (tos)
   );

   pdrf_ptr_reg #(.DW(DW), .PRESENT(ACC_EXT)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .op_i  (op),
      .top_i (tos),
      .ptr_o (ip)
   );

   assert_narrow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !wide) |=> (tos[DW-1:NARROW] == '0 && tos[NARROW-1:0] == $past(ld_data[NARROW-1:0])));

   assert_exchange_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_XCHG && !ld_en) |=> (tos == $past(ip) && ip == $past(tos)));

endmodule

// File: tb/pushdown_regfile_test.sv
module pushdown_regfile_test;

   localparam int unsigned DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_en = 1'b0;
   logic [DW-1:0] ld_data = '0;
   logic          wide = 1'b1;
   logic [1:0]    cmd = 2'b00;
   logic [1:0]    mod = 2'b00;
   logic [DW-1:0] tos, ip;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pushdown_regfile #(.DW(DW), .ACC_EXT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
      .wide(wide), .cmd(cmd), .mod(mod), .tos(tos), .ip(ip)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one cycle of stimulus, return at the next falling edge
   task automatic step(input logic [1:0] c, input logic [1:0] m,
                       input logic l, input logic [DW-1:0] d, input logic w);
      @(negedge clk);
      cmd = c; mod = m; ld_en = l; ld_data = d; wide = w;
      @(negedge clk);
      cmd = 2'b00; mod = 2'b00; ld_en = 1'b0; ld_data = '0; wide = 1'b1;
   endtask

   task automatic load16(input logic [DW-1:0] d);
      step(2'b00, 2'b00, 1'b1, d, 1'b1);
   endtask

   // read all three entries through three plain rotates (order restored)
   task automatic check_stack(input string tag, input logic [DW-1:0] et,
                              input logic [DW-1:0] en, input logic [DW-1:0] eb);
      check({tag, " top"}, tos, et);
      step(2'b11, 2'b00, 1'b0, '0, 1'b1);
      check({tag, " next"}, tos, en);
      step(2'b11, 2'b00, 1'b0, '0, 1'b1);
      check({tag, " bottom"}, tos, eb);
      step(2'b11, 2'b00, 1'b0, '0, 1'b1);
   endtask

   task automatic t_reset;
      check("R1 ip after reset", ip, '0);
      check_stack("R1 reset", 16'h0000, 16'h0000, 16'h0000);
   endtask

   task automatic t_load;
      load16(16'hA1B2);
      check_stack("R5 load 16", 16'hA1B2, 16'h0000, 16'h0000);
      check("R5 ip untouched by load", ip, '0);
      step(2'b00, 2'b00, 1'b1, 16'h1234, 1'b0);
      check("R6 narrow load", tos, 16'h0034);
      step(2'b00, 2'b00, 1'b1, 16'hFE98, 1'b1);
      check("R6 wide load", tos, 16'hFE98);
   endtask

   task automatic t_dup;
      load16(16'h1111);
      step(2'b01, 2'b00, 1'b0, '0, 1'b1);
      load16(16'h2222);
      step(2'b01, 2'b00, 1'b0, '0, 1'b1);
      check_stack("R2 dup", 16'h2222, 16'h2222, 16'h1111);
      load16(16'h3333);
      check_stack("R5 load after dup", 16'h3333, 16'h2222, 16'h1111);
   endtask

   task automatic t_swap_rot;
      step(2'b10, 2'b00, 1'b0, '0, 1'b1);
      check_stack("R3 swap", 16'h2222, 16'h3333, 16'h1111);
      step(2'b10, 2'b10, 1'b0, '0, 1'b1);
      check_stack("R13 swap size mod", 16'h3333, 16'h2222, 16'h1111);
      step(2'b11, 2'b00, 1'b0, '0, 1'b1);
      check_stack("R4 rotate", 16'h2222, 16'h1111, 16'h3333);
      step(2'b11, 2'b10, 1'b0, '0, 1'b1);
      check_stack("R13 rotate size mod", 16'h1111, 16'h3333, 16'h2222);
      step(2'b00, 2'b00, 1'b0, '0, 1'b1);
      check_stack("R5 idle hold", 16'h1111, 16'h3333, 16'h2222);
   endtask

   task automatic t_load_with_cmd;
      step(2'b01, 2'b00, 1'b1, 16'h4444, 1'b1);
      check_stack("R7 dup plus load", 16'h4444, 16'h1111, 16'h3333);
      step(2'b11, 2'b00, 1'b1, 16'h5555, 1'b1);
      check_stack("R7 rotate plus load", 16'h5555, 16'h3333, 16'h4444);
   endtask

   task automatic t_acc_ops;
      load16(16'hABCD);
      step(2'b10, 2'b01, 1'b0, '0, 1'b1);
      check_stack("R8 byte swap", 16'hCDAB, 16'h3333, 16'h4444);
      step(2'b11, 2'b01, 1'b0, '0, 1'b1);
      check_stack("R9 nibble rotate", 16'hBCDA, 16'h3333, 16'h4444);
      step(2'b11, 2'b01, 1'b0, '0, 1'b1);
      check("R9 second nibble rotate", tos, 16'hABCD);
   endtask

   task automatic t_pointer;
      step(2'b01, 2'b01, 1'b0, '0, 1'b1);
      check("R10 top to pointer", ip, 16'hABCD);
      check_stack("R10 stack kept", 16'hABCD, 16'h3333, 16'h4444);
      load16(16'h0F0F);
      step(2'b01, 2'b10, 1'b0, '0, 1'b1);
      check("R11 pointer to top", tos, 16'hABCD);
      check("R11 pointer kept", ip, 16'hABCD);
      check_stack("R11 lower entries", 16'hABCD, 16'h3333, 16'h4444);
      load16(16'h1357);
      step(2'b01, 2'b11, 1'b0, '0, 1'b1);
      check("R12 exchange top", tos, 16'hABCD);
      check("R12 exchange pointer", ip, 16'h1357);
      check_stack("R12 lower entries", 16'hABCD, 16'h3333, 16'h4444);
      step(2'b01, 2'b11, 1'b1, 16'h2468, 1'b1);
      check("R7 exchange plus load top", tos, 16'h2468);
      check("R12 exchange plus load pointer", ip, 16'hABCD);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_dup();
      t_swap_rot();
      t_load_with_cmd();
      t_acc_ops();
      t_pointer();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule